// File: doc/BRIEF.md
# Programmable Input Glitch Filter

This block sits between a synchronized digital input and the edge detector of a timer capture channel. It rejects short pulses and ringing by accepting a new input level only once that level has been seen on a set number of consecutive sample points. A 4-bit code picks two things at once: how often the input is sampled, and how many equal samples are needed.

Sampling never uses a derived clock. A divider inside the block makes single-cycle sample strobes. The strobe comes from the block clock itself or from a slower base tick that the caller supplies as a pulse train. Every accepted transition is late by the same number of sample periods, so the difference between two timestamps taken on the filtered signal is unchanged. Code 0 turns the filter off and passes the input straight through with no register in the path.

Top module: `glitch_filter`

## Requirements
- R1: While reset is asserted, and right after it is released, the filtered output is 0 in every filtering mode, and no sampling progress is kept.
- R2: With code 0, `filtOut` equals `rawIn` in the same cycle, with no clock edge in between.
- R3: With code 1, the input is sampled on every clock edge. The output takes a new level on the edge that sees the 2nd consecutive sample at that level.
- R4: With code 3, the input is sampled on every second clock edge, starting with the second rising edge after reset is released. The output takes a new level on the 8th consecutive sample at that level.
- R5: With code 15, the input is sampled on every 32nd clock edge at which `baseTick` is 1, counting from reset release. The output changes on the 8th consecutive sample at the new level.
- R6: A sample equal to the current output level throws away any progress. A pulse shorter than the required sample count never reaches the output.
- R7: Code 2 behaves as code 1. Codes 4 to 9 behave as code 3. Codes 10 to 14 behave as code 15.
- R8: In a filtering mode the output changes only on a sample edge, and only to the level sampled on that edge. The delay from a clean input step to the output step is therefore fixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rawIn | input | 1 | Input level, already synchronized to clk |
| filtCode | input | 4 | Filter setting: sample rate and required sample count |
| baseTick | input | 1 | One-cycle enable pulses of the slow base rate |
| filtOut | output | 1 | Filtered level for edge detection |

## Verification
The assertions take `rawIn` and `baseTick` to be synchronous to `clk`, and they take `baseTick` to be a one-cycle enable rather than a clock. The stimulus changes all inputs just after a rising edge. It holds `filtCode` fixed between resets and resets the block before each new code, so a run never mixes the progress counts of two settings. Each code goes through long holds, pulses just short of the required count, and pseudo-random toggling scaled to that code's sample period.

// File: rtl/glitch_filter_pkg.sv
package glitch_filter_pkg;
  localparam int CNT_W = 5;

  typedef enum logic [1:0] {
    SEL_BYPASS = 2'd0,
    SEL_FULL   = 2'd1,
    SEL_HALF   = 2'd2,
    SEL_SLOW   = 2'd3
  } rateSel_e;

  typedef struct packed {
    logic             sampleEn;
    logic             bypass;
    logic [CNT_W-1:0] target;
  } filtCtl_t;

  function automatic rateSel_e decodeCode(input logic [3:0] code);
    if (code == 4'd0)       return SEL_BYPASS;
    else if (code <= 4'd2)  return SEL_FULL;
    else if (code <= 4'd9)  return SEL_HALF;
    else                    return SEL_SLOW;
  endfunction
endpackage

// File: rtl/glitch_filter_ctl.sv
module glitch_filter_ctl
  import glitch_filter_pkg::*;
#(
  parameter int MID_DIV  = 2,
  parameter int SLOW_DIV = 32,
  parameter int N_FULL   = 2,
  parameter int N_MID    = 8,
  parameter int N_SLOW   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] filtCode,
  input  logic       baseTick,
  output filtCtl_t   ctl
);
  localparam int FW = (MID_DIV > 1) ? $clog2(MID_DIV) : 1;
  localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [FW-1:0] FAST_LAST = FW'(MID_DIV - 1);
  localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_DIV - 1);

  logic [FW-1:0] fastCnt;
  logic [SW-1:0] slowCnt;
  logic          fastHit;
  logic          slowHit;
  rateSel_e      sel;

  assign fastHit = (fastCnt == FAST_LAST);
  assign slowHit = baseTick && (slowCnt == SLOW_LAST);
  assign sel     = decodeCode(filtCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastCnt <= '0;
      slowCnt <= '0;
    end else begin
      fastCnt <= fastHit ? '0 : fastCnt + FW'(1);
      if (baseTick) slowCnt <= slowHit ? '0 : slowCnt + SW'(1);
    end
  end

  always_comb begin
    ctl = '0;
    unique case (sel)
      SEL_BYPASS: ctl.bypass = 1'b1;
      SEL_FULL: begin
        ctl.sampleEn = 1'b1;
        ctl.target   = CNT_W'(N_FULL);
      end
      SEL_HALF: begin
        ctl.sampleEn = fastHit;
        ctl.target   = CNT_W'(N_MID);
      end
      default: begin
        ctl.sampleEn = slowHit;
        ctl.target   = CNT_W'(N_SLOW);
      end
    endcase
  end

  // R4
  half_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sel == SEL_HALF && ctl.sampleEn && MID_DIV > 1) |=> !(sel == SEL_HALF && ctl.sampleEn));
endmodule

// File: rtl/glitch_filter_dp.sv
module glitch_filter_dp
  import glitch_filter_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rawIn,
  input  filtCtl_t ctl,
  output logic     filtOut
);
  logic             filtReg;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;

  assign cntNext = cnt + CNT_W'(1);
  assign filtOut = ctl.bypass ? rawIn : filtReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtReg <= 1'b0;
      cnt     <= '0;
    end else if (ctl.bypass) begin
      filtReg <= rawIn;
      cnt     <= '0;
    end else if (ctl.sampleEn) begin
      if (rawIn == filtReg) begin
        cnt <= '0;
      end else if (cntNext >= ctl.target) begin
        filtReg <= rawIn;
        cnt     <= '0;
      end else begin
        cnt <= cntNext;
      end
    end
  end

  // R8
  hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.bypass && !ctl.sampleEn) |=> $stable(filtReg));

  // R8
  change_to_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.bypass && ctl.sampleEn && rawIn == filtReg) |=> $stable(filtReg));

  // R6
  progress_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.bypass && ctl.sampleEn && rawIn == filtReg) |=> cnt == '0);

  // R1
  reset_level_chk: assert property (@(posedge clk)
    (!rstN) |-> (filtReg == 1'b0 && cnt == '0));
endmodule

// File: rtl/glitch_filter.sv
module glitch_filter
  import glitch_filter_pkg::*;
#(
  parameter int MID_DIV  = 2,
  parameter int SLOW_DIV = 32,
  parameter int N_FULL   = 2,
  parameter int N_MID    = 8,
  parameter int N_SLOW   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rawIn,
  input  logic [3:0] filtCode,
  input  logic       baseTick,
  output logic       filtOut
);
  filtCtl_t ctl;

  glitch_filter_ctl #(
    .MID_DIV(MID_DIV), .SLOW_DIV(SLOW_DIV),
    .N_FULL(N_FULL), .N_MID(N_MID), .N_SLOW(N_SLOW)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .filtCode(filtCode), .baseTick(baseTick), .ctl(ctl)
  );

  glitch_filter_dp u_dp (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .ctl(ctl), .filtOut(filtOut)
  );
endmodule

// File: tb/glitch_filter_bench.sv
module glitch_filter_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rawIn = 1'b0;
  logic [3:0] filtCode = 4'd3;
  logic       baseTick = 1'b0;
  logic       filtOut;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit finished = 0;
  string curReq = "R1";
  int seed = 7;
  int tickCnt = 0;

  // reference model state
  int mFast = 0, mBase = 0, mCnt = 0, mReg = 0;

  glitch_filter u_glitch_filter (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .filtCode(filtCode),
    .baseTick(baseTick), .filtOut(filtOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    #1;
    tickCnt++;
    baseTick <= (tickCnt % 4 != 3);
  end

  function automatic int modeOf(input int code);
    if (code == 0) return 0;
    if (code <= 2) return 1;
    if (code <= 9) return 2;
    return 3;
  endfunction

  function automatic int needOf(input int mode);
    return (mode == 1) ? 2 : 8;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mFast = 0; mBase = 0; mCnt = 0; mReg = 0;
    end else begin
      int md;
      bit strobe;
      md = modeOf(int'(filtCode));
      strobe = (md == 1) || (md == 2 && mFast == 1) ||
               (md == 3 && baseTick && mBase == 31);
      mFast = (mFast + 1) % 2;
      if (baseTick) mBase = (mBase + 1) % 32;
      if (md == 0) begin
        mReg = int'(rawIn); mCnt = 0;
      end else if (strobe) begin
        if (int'(rawIn) == mReg) mCnt = 0;
        else if (mCnt + 1 >= needOf(md)) begin mReg = int'(rawIn); mCnt = 0; end
        else mCnt++;
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      logic expv;
      expv = (modeOf(int'(filtCode)) == 0) ? rawIn : logic'(mReg[0]);
      check(curReq, filtOut, expv);
    end
  end

  task automatic stepEdge();
    @(posedge clk); #1;
  endtask

  task automatic doReset(input logic [3:0] code);
    stepEdge();
    rstN = 1'b0; rawIn = 1'b0; filtCode = code;
    stepEdge(); stepEdge();
    rstN = 1'b1;
  endtask

  task automatic hold(input logic lvl, input int cyc);
    rawIn = lvl;
    for (int i = 0; i < cyc; i++) stepEdge();
  endtask

  task automatic runPattern(input logic [3:0] code, input string req);
    int u;
    int md;
    md = modeOf(int'(code));
    u = (md == 3) ? 43 : ((md == 2) ? 2 : 1);
    curReq = req;
    doReset(code);
    hold(1'b1, 12 * u);
    hold(1'b0, (needOf(md) - 1) * u);
    hold(1'b1, 12 * u);
    hold(1'b0, 12 * u);
    hold(1'b1, (needOf(md) - 1) * u);
    hold(1'b0, 10 * u);
    for (int k = 0; k < 30; k++) begin
      seed = seed * 1103515245 + 12345;
      hold(~rawIn, ((((seed >>> 16) & 32'h7fff) % 10) + 1) * u);
    end
    hold(rawIn, 12 * u);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: output low during and right after reset, even with input high
    filtCode = 4'd3;
    stepEdge();
    rawIn = 1'b1;
    #2 check("R1", filtOut, 1'b0);
    rstN = 1'b1; rawIn = 1'b0;
    stepEdge();
    #2 check("R1", filtOut, 1'b0);
    started = 1;

    // R2: bypass passes the input with no edge in between
    curReq = "R2";
    doReset(4'd0);
    @(negedge clk); rawIn = 1'b1; #1 check("R2", filtOut, 1'b1);
    rawIn = 1'b0; #1 check("R2", filtOut, 1'b0);
    stepEdge();

    // R3: two consecutive samples needed at full rate
    curReq = "R3";
    doReset(4'd1);
    rawIn = 1'b1;
    stepEdge(); check("R3", filtOut, 1'b0);
    stepEdge(); check("R3", filtOut, 1'b1);

    // R6: one-sample pulse never reaches the output
    curReq = "R6";
    doReset(4'd1);
    rawIn = 1'b1; stepEdge(); rawIn = 1'b0;
    for (int i = 0; i < 5; i++) begin stepEdge(); check("R6", filtOut, 1'b0); end

    // R4: half rate, eight samples; first strobe on second edge after release
    curReq = "R4";
    doReset(4'd3);
    rawIn = 1'b1;
    for (int i = 0; i < 15; i++) stepEdge();
    check("R4", filtOut, 1'b0);
    stepEdge(); check("R4", filtOut, 1'b1);

    runPattern(4'd0, "R2");
    runPattern(4'd1, "R3");
    runPattern(4'd3, "R4");
    runPattern(4'd15, "R5");
    runPattern(4'd2, "R7");
    runPattern(4'd5, "R7");
    runPattern(4'd9, "R7");
    runPattern(4'd10, "R7");
    runPattern(4'd1, "R8");
    runPattern(4'd12, "R6");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule